// File: doc/BRIEF.md
# Daisy-Chained Serial Slave Command Decoder

This block is the serial control front end of a device that carries two line channels and sits on a daisy chain of up to sixteen such devices. All devices on the chain share a serial clock and a chip select. Each transaction is three bytes long: a control byte, an address byte and a data byte. The control byte has a broadcast flag, a read/write flag, a register-or-RAM space flag, one reserved bit and a 4-bit channel ID.

Addressing depends on position in the chain. The channel ID arrives least significant bit first. Each local channel subtracts one from it bit-serially, and the channel that receives zero is the one addressed. The rewritten serial stream goes out on a pass-through pin to the next device. When the broadcast flag is set, the ID passes through unchanged and every channel accepts the write. A matched write gives one pulse on a simple register-file port. A matched read fetches one byte from that port and shifts it out on the serial output. The output enable is high only for that data byte, so the input and output pins can be tied together.

The serial pins are oversampled. Serial clock, chip select and data in each pass through a synchronizer into the block clock domain. A chip select that is asserted again partway through a byte returns the framing to the control byte.

Top module: `chain_spi_slave`

## Requirements
- R1: The control byte arrives most significant bit first. The first bit is broadcast. The second is read (1) or write (0). The third is the space, shown on rf_reg as 1 for register and 0 for RAM. The fourth is reserved and has no effect. The last four bits carry the channel ID least significant bit first: byte bit 3 is ID bit 0 and byte bit 0 is ID bit 3.
- R2: sdi_thru repeats sdi, delayed by SYNC_STAGES+1 clk cycles. The one exception is the ID field of a control byte whose broadcast bit is clear. That field carries the received ID minus NUM_CH, modulo 16, in the same least-significant-first order. With broadcast set, the field is passed through unchanged.
- R3: Local channel k (k from 0 to NUM_CH-1) is addressed when the received ID equals k, and rf_sel bit k marks it. An ID of NUM_CH or more addresses no local channel.
- R4: An addressed write gives exactly one clk cycle of rf_we after the last rising SCLK edge of the data byte. In that cycle rf_sel is one-hot, rf_addr holds the second byte and rf_wdata holds the third byte, both received most significant bit first.
- R5: A broadcast write pulses rf_we with every rf_sel bit set, whatever the ID. A broadcast read gives no rf_re and leaves sdo_oe low.
- R6: An addressed read gives one rf_re pulse after the address byte, with rf_sel one-hot and rf_addr valid. The rf_rdata value from that cycle goes out on sdo most significant bit first. Each bit is updated after a falling SCLK edge of the data byte, and sdo changes at no other time.
- R7: sdo_oe is high only during the data byte of an addressed read without broadcast. It is high on every bit of that byte. It is low during control and address bytes, during writes and unaddressed reads, and from the cycle after CS is seen deasserted.
- R8: A transaction that addresses no local channel produces neither rf_we nor rf_re.
- R9: If CS becomes asserted while the bit count within the current byte is not zero, the next bit is taken as the first bit of a control byte.
- R10: During and right after reset, rf_we, rf_re, sdo_oe and sdo are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock, idles high, toggles only during bytes |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdi_thru | output | 1 | Pass-through serial data to the next device, with the ID rewritten |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Tri-state enable for sdo |
| rf_we | output | 1 | One-cycle write strobe to the register file |
| rf_re | output | 1 | One-cycle read strobe to the register file |
| rf_sel | output | NUM_CH | Local channels targeted by the access |
| rf_reg | output | 1 | Access space: 1 register, 0 RAM |
| rf_addr | output | 8 | Access address |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Read data, valid in the same cycle as rf_re |

## Verification
The bench uses the defaults NUM_CH=2 and SYNC_STAGES=2, with a serial half period of eight block clocks. With two channels, IDs 0 and 1 are the only matches. ID 2 is the first one passed on without a match, and the IDs 0 and 1 wrap to 14 and 15 on the pass-through pin. Both the matched and the wrap-around cases are covered by directed and random transactions. The two-stage synchronizer still leaves enough of each half period to check that sdo and the rewritten pass-through bits settle before the next rising edge.

// File: rtl/csl_pkg.sv
package csl_pkg;
  localparam int BYTE_W    = 8;
  localparam int CID_W     = 4;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  // arrival slots within the control byte (slot 0 is the first bit shifted in)
  localparam int SLOT_BCAST = 0;
  localparam int SLOT_READ  = 1;
  localparam int SLOT_SPACE = 2;
  localparam int SLOT_CID   = BYTE_W - CID_W;

  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/csl_rst_sync.sv
module csl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/csl_in_sync.sv
module csl_in_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= {sr_q[STAGES-2:0], d};
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/csl_cid_stage.sv
// One channel's bit-serial decrement of the LSB-first channel ID, plus its
// "received zero" detector.
module csl_cid_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic init,     // start of a control byte: preload borrow and zero
  input  logic step,     // one ID bit is being consumed this cycle
  input  logic active,   // ID slot and decrement enabled (no broadcast)
  input  logic bit_in,
  output logic bit_out,
  output logic zero
);
  logic borrow_q, borrow_d;
  logic zero_q, zero_d;

  assign bit_out = active ? (bit_in ^ borrow_q) : bit_in;
  assign zero    = zero_q;

  always_comb begin
    borrow_d = borrow_q;
    zero_d   = zero_q;
    if (init) begin
      borrow_d = 1'b1;
      zero_d   = 1'b1;
    end else if (step) begin
      borrow_d = borrow_q & ~bit_in;
      zero_d   = zero_q & ~bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      borrow_q <= 1'b0;
      zero_q   <= 1'b0;
    end else begin
      borrow_q <= borrow_d;
      zero_q   <= zero_d;
    end
  end

  // R2: a cleared borrow never comes back within one ID field
  p_borrow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!borrow_q && !init) |=> !borrow_q)
    else $error("borrow reappeared without init");

  // R3: once a nonzero ID bit is seen, the channel stays unmatched until init
  p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero_q && !init) |=> !zero_q)
    else $error("zero flag reappeared without init");
endmodule

// File: rtl/chain_spi_slave.sv
module chain_spi_slave
  import csl_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdi_thru,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              rf_we,
  output logic              rf_re,
  output logic [NUM_CH-1:0] rf_sel,
  output logic              rf_reg,
  output logic [BYTE_W-1:0] rf_addr,
  output logic [BYTE_W-1:0] rf_wdata,
  input  logic [BYTE_W-1:0] rf_rdata
);
  localparam logic [BIT_IDX_W-1:0] BIT_LAST = BIT_IDX_W'(BYTE_W - 1);
  localparam logic [BIT_IDX_W-1:0] B_BCAST  = BIT_IDX_W'(SLOT_BCAST);
  localparam logic [BIT_IDX_W-1:0] B_READ   = BIT_IDX_W'(SLOT_READ);
  localparam logic [BIT_IDX_W-1:0] B_SPACE  = BIT_IDX_W'(SLOT_SPACE);
  localparam logic [BIT_IDX_W-1:0] B_CID    = BIT_IDX_W'(SLOT_CID);

  // ---------------- reset and input synchronisation ----------------
  logic rst_n_s, sclk_s, cs_s, sdi_s;

  csl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));
  csl_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk (
    .clk(clk), .rst_n(rst_n_s), .d(sclk), .q(sclk_s));
  csl_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n_s), .d(cs_n), .q(cs_s));
  csl_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi (
    .clk(clk), .rst_n(rst_n_s), .d(sdi), .q(sdi_s));

  logic sclk_d_q, cs_d_q;
  logic rise_ev, fall_ev, cs_fall, soft_rst;

  assign rise_ev  = sclk_s & ~sclk_d_q & ~cs_s;
  assign fall_ev  = ~sclk_s & sclk_d_q & ~cs_s;
  assign cs_fall  = ~cs_s & cs_d_q;

  // ---------------- frame state ----------------
  phase_e                ph_q, ph_d;
  logic [BIT_IDX_W-1:0]  bit_q, bit_d;
  logic                  bcast_q, bcast_d, rd_q, rd_d, space_q, space_d;
  logic [BYTE_W-1:0]     addr_q, addr_d, data_q, data_d, tx_q, tx_d;
  logic [NUM_CH-1:0]     sel_q, sel_d;
  logic                  sdo_q, sdo_d, oe_q, oe_d;
  logic                  re_q, re_d, we_q, we_d, thru_q;
  logic                  last_bit, cid_slot, rd_ok, wr_ok;

  assign last_bit = (bit_q == BIT_LAST);
  assign soft_rst = cs_fall && (bit_q != '0);
  assign cid_slot = (ph_q == PH_CTRL) && (bit_q >= B_CID);

  // ---------------- per-channel ID decrement chain ----------------
  logic [NUM_CH:0]   chain_bit;
  logic [NUM_CH-1:0] ch_zero;
  logic              id_init, id_step, id_active;

  assign chain_bit[0] = sdi_s;
  assign id_init      = rise_ev && (ph_q == PH_CTRL) && (bit_q == '0);
  assign id_step      = rise_ev && cid_slot;
  assign id_active    = cid_slot && !bcast_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    csl_cid_stage u_stage (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .init   (id_init),
      .step   (id_step),
      .active (id_active),
      .bit_in (chain_bit[g]),
      .bit_out(chain_bit[g+1]),
      .zero   (ch_zero[g])
    );
  end

  assign rd_ok = rd_q && !bcast_q && (|ch_zero);
  assign wr_ok = !rd_q && (bcast_q || (|ch_zero));

  // ---------------- next state ----------------
  always_comb begin
    ph_d    = ph_q;
    bit_d   = bit_q;
    bcast_d = bcast_q;
    rd_d    = rd_q;
    space_d = space_q;
    addr_d  = addr_q;
    data_d  = data_q;
    tx_d    = tx_q;
    sel_d   = sel_q;
    sdo_d   = sdo_q;
    oe_d    = oe_q;
    re_d    = 1'b0;
    we_d    = 1'b0;

    if (re_q) tx_d = rf_rdata;

    if (soft_rst) begin
      ph_d  = PH_CTRL;
      bit_d = '0;
      oe_d  = 1'b0;
    end else if (rise_ev) begin
      bit_d = last_bit ? '0 : bit_q + 1'b1;
      unique case (ph_q)
        PH_CTRL: begin
          if (bit_q == B_BCAST) bcast_d = sdi_s;
          if (bit_q == B_READ)  rd_d    = sdi_s;
          if (bit_q == B_SPACE) space_d = sdi_s;
          if (last_bit)         ph_d    = PH_ADDR;
        end
        PH_ADDR: begin
          addr_d = {addr_q[BYTE_W-2:0], sdi_s};
          if (last_bit) begin
            ph_d = PH_DATA;
            if (rd_ok) begin
              re_d  = 1'b1;
              sel_d = ch_zero;
            end
          end
        end
        PH_DATA: begin
          data_d = {data_q[BYTE_W-2:0], sdi_s};
          if (last_bit) begin
            ph_d = PH_CTRL;
            oe_d = 1'b0;
            if (wr_ok) begin
              we_d  = 1'b1;
              sel_d = bcast_q ? '1 : ch_zero;
            end
          end
        end
        default: ph_d = PH_CTRL;
      endcase
    end else if (fall_ev && (ph_q == PH_DATA) && rd_ok) begin
      sdo_d = tx_q[BYTE_W-1];
      tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
      oe_d  = 1'b1;
    end

    if (cs_s) oe_d = 1'b0;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sclk_d_q <= 1'b1;
      cs_d_q   <= 1'b1;
      ph_q     <= PH_CTRL;
      bit_q    <= '0;
      bcast_q  <= 1'b0;
      rd_q     <= 1'b0;
      space_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      tx_q     <= '0;
      sel_q    <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
      re_q     <= 1'b0;
      we_q     <= 1'b0;
      thru_q   <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      cs_d_q   <= cs_s;
      ph_q     <= ph_d;
      bit_q    <= bit_d;
      bcast_q  <= bcast_d;
      rd_q     <= rd_d;
      space_q  <= space_d;
      addr_q   <= addr_d;
      data_q   <= data_d;
      tx_q     <= tx_d;
      sel_q    <= sel_d;
      sdo_q    <= sdo_d;
      oe_q     <= oe_d;
      re_q     <= re_d;
      we_q     <= we_d;
      thru_q   <= chain_bit[NUM_CH];
    end
  end

  assign sdi_thru = thru_q;
  assign sdo      = sdo_q;
  assign sdo_oe   = oe_q;
  assign rf_we    = we_q;
  assign rf_re    = re_q;
  assign rf_sel   = sel_q;
  assign rf_reg   = space_q;
  assign rf_addr  = addr_q;
  assign rf_wdata = data_q;

  // ---------------- assertions ----------------
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    rf_we |=> !rf_we) else $error("write strobe longer than one cycle");

  p_re_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    rf_re |=> !rf_re) else $error("read strobe longer than one cycle");

  p_we_re_excl_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    rf_we |-> !rf_re) else $error("read and write strobes together");

  p_read_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    rf_re |-> ($countones(rf_sel) == 1)) else $error("read selects not one-hot");

  p_no_bcast_read_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    rf_re |-> !bcast_q) else $error("read issued under broadcast");

  p_oe_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    sdo_oe |-> (rd_q && !bcast_q && ph_q == PH_DATA))
    else $error("output enabled outside a read data byte");

  p_oe_drops_cs_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_s |=> !sdo_oe) else $error("output enabled while deselected");

  p_sdo_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !fall_ev |=> $stable(sdo)) else $error("sdo moved without a falling edge");

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    soft_rst |=> (ph_q == PH_CTRL && bit_q == '0))
    else $error("mid-byte select did not reframe");
endmodule

// File: tb/chain_spi_slave_bench.sv
module chain_spi_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 2;
  localparam int HALF       = 8;

  logic clk, rst_n, sclk, cs_n, sdi;
  logic sdi_thru, sdo, sdo_oe, rf_we, rf_re, rf_reg;
  logic [NCH-1:0] rf_sel;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;

  int n_chk = 0;
  int n_bad = 0;

  chain_spi_slave #(.NUM_CH(NCH), .SYNC_STAGES(2)) u_chain_spi_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdi_thru(sdi_thru), .sdo(sdo), .sdo_oe(sdo_oe),
    .rf_we(rf_we), .rf_re(rf_re), .rf_sel(rf_sel), .rf_reg(rf_reg),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rd_pat(logic ch, logic rg, logic [7:0] a);
    return {a[3:0], a[7:4]} ^ {ch, rg, 6'h2b};
  endfunction

  assign rf_rdata = rd_pat(rf_sel[1], rf_reg, rf_addr);

  // register-file side monitor
  int we_tot = 0;
  int re_tot = 0;
  logic [NCH-1:0] we_sel;
  logic [7:0] we_addr, we_data;
  logic we_reg;
  always @(negedge clk) begin
    if (rf_we) begin
      we_tot++;
      we_sel  = rf_sel;
      we_addr = rf_addr;
      we_data = rf_wdata;
      we_reg  = rf_reg;
    end
    if (rf_re) re_tot++;
  end

  function automatic logic [7:0] mk_ctrl(logic bc, logic rd, logic rg, logic rsv, logic [3:0] id);
    return {bc, rd, rg, rsv, id[0], id[1], id[2], id[3]};
  endfunction

  function automatic logic [7:0] exp_thru(logic [7:0] c);
    logic [3:0] id, nid;
    id  = {c[0], c[1], c[2], c[3]};
    nid = c[7] ? id : id - 4'(NCH);
    return {c[7:4], nid[0], nid[1], nid[2], nid[3]};
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] thru,
                           output logic [7:0] so, output int oe_hi);
    oe_hi = 0;
    cs_n = 1'b0;
    ticks(HALF);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0;
      sdi  = b[i];
      ticks(HALF);
      thru[i] = sdi_thru;
      so[i]   = sdo;
      if (sdo_oe) oe_hi++;
      sclk = 1'b1;
      ticks(HALF);
    end
    cs_n = 1'b1;
    ticks(HALF);
  endtask

  task automatic run_case(input logic [7:0] ctrl, input logic [7:0] addr, input logic [7:0] wdat);
    logic [7:0] t0, t1, t2, s0, s1, s2;
    int o0, o1, o2, we0, re0;
    logic bc, rd, rg, hit;
    logic [3:0] id;
    bc  = ctrl[7];
    rd  = ctrl[6];
    rg  = ctrl[5];
    id  = {ctrl[0], ctrl[1], ctrl[2], ctrl[3]};
    hit = (id < 4'(NCH));
    we0 = we_tot;
    re0 = re_tot;
    send_byte(ctrl, t0, s0, o0);
    send_byte(addr, t1, s1, o1);
    send_byte(wdat, t2, s2, o2);
    ticks(HALF);
    check(t0 == exp_thru(ctrl), "R2", "thru control byte", t0, exp_thru(ctrl));
    check(t1 == addr && t2 == wdat, "R2", "thru addr/data", {t1, t2}, {addr, wdat});
    check(o0 + o1 == 0, "R7", "oe in ctrl/addr bytes", o0 + o1, 0);
    check(sdo_oe == 1'b0, "R7", "oe after deselect", sdo_oe, 0);
    if (rd) begin
      check(we_tot == we0, "R8", "write on a read", we_tot - we0, 0);
      if (!bc && hit) begin
        check(re_tot - re0 == 1, "R6", "read strobe count", re_tot - re0, 1);
        check(s2 == rd_pat(id[0], rg, addr), "R6", "sdo read byte", s2, rd_pat(id[0], rg, addr));
        check(o2 == 8, "R7", "oe bits in read data", o2, 8);
      end else begin
        check(re_tot == re0, bc ? "R5" : "R8", "read strobe on bcast/unaddressed", re_tot - re0, 0);
        check(o2 == 0, "R7", "oe on bcast/unaddressed read", o2, 0);
      end
    end else begin
      check(re_tot == re0, "R8", "read strobe on a write", re_tot - re0, 0);
      check(o2 == 0, "R7", "oe on a write", o2, 0);
      if (bc || hit) begin
        check(we_tot - we0 == 1, bc ? "R5" : "R4", "write strobe count", we_tot - we0, 1);
        check(we_sel == (bc ? 2'b11 : 2'(1 << id)), bc ? "R5" : "R3", "write select",
              we_sel, bc ? 2'b11 : 2'(1 << id));
        check(we_addr == addr && we_data == wdat, "R4", "write addr/data",
              {we_addr, we_data}, {addr, wdat});
        check(we_reg == rg, "R1", "space flag", we_reg, rg);
      end else begin
        check(we_tot == we0, "R8", "write on unaddressed", we_tot - we0, 0);
      end
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    rst_n = 1'b0;
    sclk  = 1'b1;
    cs_n  = 1'b1;
    sdi   = 1'b0;
    ticks(5);
    // R10: idle outputs during and right after reset
    check(!rf_we && !rf_re && !sdo_oe && !sdo, "R10", "outputs in reset",
          {rf_we, rf_re, sdo_oe, sdo}, 0);
    rst_n = 1'b1;
    ticks(6);
    check(!rf_we && !rf_re && !sdo_oe && !sdo, "R10", "outputs after reset",
          {rf_we, rf_re, sdo_oe, sdo}, 0);
    sdi = 1'b1;
    ticks(6);
    check(sdi_thru == 1'b1, "R2", "idle pass-through", sdi_thru, 1);
    sdi = 1'b0;

    // directed corner cases
    run_case(mk_ctrl(0, 0, 1, 0, 4'd0),  8'h12, 8'hA5); // R4 write ch0 register
    run_case(mk_ctrl(0, 0, 0, 0, 4'd1),  8'h34, 8'h5A); // R3 write ch1 RAM
    run_case(mk_ctrl(0, 0, 1, 1, 4'd2),  8'h56, 8'h0F); // R8 first unaddressed id
    run_case(mk_ctrl(0, 1, 1, 0, 4'd0),  8'h77, 8'h00); // R6 read ch0
    run_case(mk_ctrl(0, 1, 0, 1, 4'd1),  8'hC3, 8'hFF); // R1 reserved bit ignored
    run_case(mk_ctrl(1, 0, 0, 0, 4'd9),  8'h40, 8'h3C); // R5 broadcast write
    run_case(mk_ctrl(1, 1, 1, 0, 4'd0),  8'h41, 8'h00); // R5 broadcast read silent
    run_case(mk_ctrl(0, 0, 1, 0, 4'd15), 8'h99, 8'h66); // R2 no wrap, unaddressed
    run_case(mk_ctrl(0, 1, 1, 0, 4'd1),  8'h08, 8'h11); // R2 wraps to 15

    // R9: three bits, drop select, reselect, then a clean write
    cs_n = 1'b0;
    ticks(HALF);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; sdi = 1'b1; ticks(HALF);
      sclk = 1'b1; ticks(HALF);
    end
    cs_n = 1'b1;
    ticks(2 * HALF);
    run_case(mk_ctrl(0, 0, 1, 0, 4'd0), 8'h2E, 8'h96);
    check(we_data == 8'h96 && we_addr == 8'h2E, "R9", "write after soft reset",
          {we_addr, we_data}, {8'h2E, 8'h96});

    // constrained random traffic
    seed = $urandom(32'd20240);
    for (int k = 0; k < 60; k++) begin
      logic [3:0] id;
      logic bc;
      id = (($urandom % 4) == 0) ? 4'($urandom % 16) : 4'($urandom % 3);
      bc = (($urandom % 6) == 0);
      run_case(mk_ctrl(bc, 1'($urandom), 1'($urandom), 1'($urandom), id),
               8'($urandom), 8'($urandom));
    end

    summary();
    $finish;
  end
endmodule